// File: doc/BRIEF.md
# Variable-Length Instruction Extractor

This block sits between a ring-shaped instruction fetch store and a per-wave instruction queue. It owns the read pointer of the ring, reads raw dwords at that pointer and hands one instruction per cycle to the queue through a valid/ready push. Instructions are either one dword or two dwords long. One bit of the first dword gives the length, and the raw bits pass through undecoded. The producer that fills the ring keeps the write pointer and gives it to the block. The block returns its read pointer so that the producer can see how much space is free.

Extraction starts only when at least two dwords are unread, which is the size of the largest instruction. An instruction whose first dword sits in the last slot of the ring is gathered in two steps. The first step copies the last dword into a holding register and wraps the pointer to slot zero. The second step joins that copy with the dword in slot zero and moves the pointer past whatever part of the instruction lies in slot zero. A flush reloads the read pointer and discards any half-gathered instruction.

Top module: `insx_extract`

## Requirements
- R1: While reset is held, `rdPtr` is zero and `outValid` is low.
- R2: No instruction is offered unless at least two dwords are unread (`wrPtr - rdPtr`, modulo twice the ring depth, is 2 or more). This applies even when the next instruction is one dword long.
- R3: While `outValid` is high and `outReady` is low, `rdPtr` and the offered instruction do not change.
- R4: Bit `LEN_BIT` (default 0) of the first dword set to 1 marks a two-dword instruction. Then `outLong` is 1 and `outInst` is {second dword, first dword}. With the bit clear, `outLong` is 0 and `outInst[63:32]` is zero.
- R5: An instruction taken from any slot except the last advances `rdPtr` by 1 or 2 dwords. A two-dword instruction that ends exactly at the ring end wraps the index to 0 and toggles the wrap bit (bit PW).
- R6: When `rdPtr` points at the last slot and two dwords are unread, the block copies that dword and wraps `rdPtr` to slot 0 in one cycle without offering anything. From the next cycle it offers the instruction built from the copied dword and the dword in slot 0.
- R7: When a wrapped instruction is taken, `rdPtr` advances by its length minus one dword: it ends on slot 1 for a two-dword instruction and stays on slot 0 for a one-dword instruction.
- R8: `flush` loads `rdPtr` from `flushPtr` at the next edge, forces `outValid` low in the flush cycle, and discards any partly gathered wrapped instruction.
- R9: At most one instruction is taken per cycle, and the taken stream equals the written stream in order, under any backpressure pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop the pending work and reload the read pointer |
| flushPtr | input | PW+1 | New read pointer (slot index plus wrap bit) |
| wrPtr | input | PW+1 | Producer write pointer (slot index plus wrap bit) |
| rdAddrLo | output | PW | Ring slot read at the current pointer |
| rdAddrHi | output | PW | Ring slot after the current pointer |
| rdDataLo | input | 32 | Dword stored at `rdAddrLo` |
| rdDataHi | input | 32 | Dword stored at `rdAddrHi` |
| rdPtr | output | PW+1 | Read pointer (slot index plus wrap bit) |
| outValid | output | 1 | Instruction offered to the queue |
| outReady | input | 1 | Queue has room |
| outInst | output | 64 | Raw instruction bits |
| outLong | output | 1 | Offered instruction is two dwords |

## Verification
The hardest state to reach is the held half of a wrapped instruction: the pointer has to land on the last slot exactly, and the queue has to refuse long enough to observe the holding state or to flush in the middle of it. The stimulus gets there by using a flush to park the pointer on the last slot, writing two dwords while ready is forced low, and then either releasing ready or flushing to a new pointer. A long stream under pseudo-random backpressure follows, with mixed lengths that cross the ring end at many alignments.

// File: rtl/insx_pkg.sv
package insx_pkg;
  localparam int INST_W = 64;
  localparam int DW_W   = 32;

  typedef struct packed {
    logic offerNorm;
    logic offerSplit;
    logic gather;
    logic takeNorm;
    logic takeSplit;
    logic flush;
  } insxStrobes_t;
endpackage

// File: rtl/insx_ctrl.sv
module insx_ctrl
  import insx_pkg::*;
#(
  parameter int DEPTH_DW = 16,
  localparam int PW = $clog2(DEPTH_DW),
  localparam int PTRW = PW + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            flush,
  input  logic            outReady,
  input  logic [PTRW-1:0] unreadDw,
  input  logic            atLast,
  output insxStrobes_t    strobes
);
  localparam int MAX_INST_DW = 2;

  typedef enum logic {ST_SCAN, ST_HOLD} ctrlState_t;
  ctrlState_t state, stateNext;

  logic enough;
  assign enough = unreadDw >= PTRW'(MAX_INST_DW);

  always_comb begin
    strobes   = '0;
    stateNext = state;
    if (flush) begin
      strobes.flush = 1'b1;
      stateNext     = ST_SCAN;
    end else if (state == ST_HOLD) begin
      strobes.offerSplit = 1'b1;
      strobes.takeSplit  = outReady;
      if (outReady) stateNext = ST_SCAN;
    end else if (enough) begin
      if (atLast) begin
        strobes.gather = 1'b1;
        stateNext      = ST_HOLD;
      end else begin
        strobes.offerNorm = 1'b1;
        strobes.takeNorm  = outReady;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_SCAN;
    else       state <= stateNext;
  end
endmodule

// File: rtl/insx_datapath.sv
module insx_datapath
  import insx_pkg::*;
#(
  parameter int DEPTH_DW = 16,
  parameter int LEN_BIT  = 0,
  localparam int PW = $clog2(DEPTH_DW),
  localparam int PTRW = PW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  insxStrobes_t      strobes,
  input  logic [PTRW-1:0]   flushPtr,
  input  logic [PTRW-1:0]   wrPtr,
  input  logic [DW_W-1:0]   rdDataLo,
  input  logic [DW_W-1:0]   rdDataHi,
  output logic [PW-1:0]     rdAddrLo,
  output logic [PW-1:0]     rdAddrHi,
  output logic [PTRW-1:0]   rdPtr,
  output logic [PTRW-1:0]   unreadDw,
  output logic              atLast,
  output logic              outValid,
  output logic [INST_W-1:0] outInst,
  output logic              outLong
);
  logic [PW-1:0]   rdIdx;
  logic [DW_W-1:0] holdDw;
  logic [DW_W-1:0] firstDw;
  logic [DW_W-1:0] secondDw;
  logic [PTRW-1:0] rdPtrNext;

  assign rdIdx    = rdPtr[PW-1:0];
  assign atLast   = rdIdx == PW'(DEPTH_DW - 1);
  assign unreadDw = wrPtr - rdPtr;
  assign rdAddrLo = rdIdx;
  assign rdAddrHi = rdIdx + PW'(1);

  // a held wrap uses the copied tail dword first, slot zero second
  assign firstDw  = strobes.offerSplit ? holdDw   : rdDataLo;
  assign secondDw = strobes.offerSplit ? rdDataLo : rdDataHi;
  assign outLong  = firstDw[LEN_BIT];
  assign outInst  = outLong ? {secondDw, firstDw} : {{DW_W{1'b0}}, firstDw};
  assign outValid = strobes.offerNorm | strobes.offerSplit;

  always_comb begin
    rdPtrNext = rdPtr;
    if (strobes.flush)
      rdPtrNext = flushPtr;
    else if (strobes.gather)
      rdPtrNext = rdPtr + PTRW'(1);
    else if (strobes.takeNorm)
      rdPtrNext = rdPtr + (outLong ? PTRW'(2) : PTRW'(1));
    else if (strobes.takeSplit)
      rdPtrNext = rdPtr + (outLong ? PTRW'(1) : PTRW'(0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr  <= '0;
      holdDw <= '0;
    end else begin
      rdPtr <= rdPtrNext;
      if (strobes.gather) holdDw <= rdDataLo;
    end
  end
endmodule

// File: rtl/insx_extract.sv
module insx_extract
  import insx_pkg::*;
#(
  parameter int DEPTH_DW = 16,
  parameter int LEN_BIT  = 0,
  localparam int PW = $clog2(DEPTH_DW),
  localparam int PTRW = PW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic [PTRW-1:0]   flushPtr,
  input  logic [PTRW-1:0]   wrPtr,
  output logic [PW-1:0]     rdAddrLo,
  output logic [PW-1:0]     rdAddrHi,
  input  logic [DW_W-1:0]   rdDataLo,
  input  logic [DW_W-1:0]   rdDataHi,
  output logic [PTRW-1:0]   rdPtr,
  output logic              outValid,
  input  logic              outReady,
  output logic [INST_W-1:0] outInst,
  output logic              outLong
);
  insxStrobes_t    strobes;
  logic [PTRW-1:0] unreadDw;
  logic            atLast;

  insx_ctrl #(.DEPTH_DW(DEPTH_DW)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flush),
    .outReady (outReady),
    .unreadDw (unreadDw),
    .atLast   (atLast),
    .strobes  (strobes)
  );

  insx_datapath #(.DEPTH_DW(DEPTH_DW), .LEN_BIT(LEN_BIT)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .flushPtr (flushPtr),
    .wrPtr    (wrPtr),
    .rdDataLo (rdDataLo),
    .rdDataHi (rdDataHi),
    .rdAddrLo (rdAddrLo),
    .rdAddrHi (rdAddrHi),
    .rdPtr    (rdPtr),
    .unreadDw (unreadDw),
    .atLast   (atLast),
    .outValid (outValid),
    .outInst  (outInst),
    .outLong  (outLong)
  );
endmodule

// File: rtl/insx_extract_chk.sv
module insx_extract_chk #(
  parameter int DEPTH_DW = 16,
  localparam int PW = $clog2(DEPTH_DW),
  localparam int PTRW = PW + 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            flush,
  input logic [PTRW-1:0] flushPtr,
  input logic [PTRW-1:0] wrPtr,
  input logic [PTRW-1:0] rdPtr,
  input logic            outValid,
  input logic            outReady,
  input logic [63:0]     outInst,
  input logic            outLong
);
  logic [PTRW-1:0] unread;
  assign unread = wrPtr - rdPtr;

  AST_OFFER_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> unread != '0); // R2

  AST_HOLD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !flush) |=> $stable(rdPtr)); // R3

  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLong) |-> outInst[63:32] == 32'h0); // R4

  AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !flush && rdPtr[PW-1:0] != '0) |=>
      rdPtr == PTRW'($past(rdPtr) + ($past(outLong) ? 2 : 1))); // R5

  AST_NO_OFFER_AT_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> rdPtr[PW-1:0] != PW'(DEPTH_DW - 1)); // R6

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !outValid); // R8

  AST_FLUSH_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> rdPtr == $past(flushPtr)); // R8
endmodule

bind insx_extract insx_extract_chk #(.DEPTH_DW(DEPTH_DW)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .flush    (flush),
  .flushPtr (flushPtr),
  .wrPtr    (wrPtr),
  .rdPtr    (rdPtr),
  .outValid (outValid),
  .outReady (outReady),
  .outInst  (outInst),
  .outLong  (outLong)
);

// File: tb/insx_extract_tb_top.sv
module insx_extract_tb_top;
  localparam int DEPTH = 16;
  localparam int PW = $clog2(DEPTH);
  localparam int PTRW = PW + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic [PTRW-1:0] flushPtr = '0;
  logic [PTRW-1:0] wrPtr = '0;
  logic [PW-1:0] rdAddrLo, rdAddrHi;
  logic [31:0] rdDataLo, rdDataHi;
  logic [PTRW-1:0] rdPtr;
  logic outValid, outLong;
  logic outReady = 1'b0;
  logic [63:0] outInst;

  logic [31:0] ring [DEPTH];
  logic [64:0] expQ [$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit rdyForce = 1'b1;
  bit rdyVal = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  assign rdDataLo = ring[rdAddrLo];
  assign rdDataHi = ring[rdAddrHi];

  insx_extract #(.DEPTH_DW(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .flush(flush), .flushPtr(flushPtr), .wrPtr(wrPtr),
    .rdAddrLo(rdAddrLo), .rdAddrHi(rdAddrHi), .rdDataLo(rdDataLo), .rdDataHi(rdDataHi),
    .rdPtr(rdPtr), .outValid(outValid), .outReady(outReady), .outInst(outInst),
    .outLong(outLong)
  );

  task automatic check(input bit ok, input string req, input logic [64:0] act,
                       input logic [64:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // ready driver: forced value or pseudo-random, applied at edge+2
  always @(posedge clk) begin
    #2;
    outReady = rdyForce ? rdyVal : lfsr[0];
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rstN && outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9 unexpected", {outLong, outInst}, '0);
        end else begin
          check({outLong, outInst} === expQ[0], "R9/R4 stream", {outLong, outInst}, expQ[0]);
          void'(expQ.pop_front());
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic putInst(input bit isLong, input logic [30:0] tag);
    int need;
    logic [31:0] lo, hi;
    need = isLong ? 2 : 1;
    lo = {tag, isLong};
    hi = 32'hC0DE_0000 ^ {1'b0, tag};
    while (DEPTH - int'(PTRW'(wrPtr - rdPtr)) < need) step();
    ring[wrPtr[PW-1:0]] = lo;
    wrPtr = wrPtr + PTRW'(1);
    if (isLong) begin
      ring[wrPtr[PW-1:0]] = hi;
      wrPtr = wrPtr + PTRW'(1);
    end
    expQ.push_back(isLong ? {1'b1, hi, lo} : {1'b0, 32'h0, lo});
  endtask

  task automatic doFlush(input logic [PTRW-1:0] p);
    flush = 1'b1;
    flushPtr = p;
    wrPtr = p;
    expQ.delete();
    #4;
    check(outValid == 1'b0, "R8 quiet", {64'h0, outValid}, '0);
    step();
    flush = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      if (expQ.size() == 0) break;
      step();
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ring[i] = '0;
    repeat (3) step();
    #4;
    check(rdPtr == '0, "R1 ptr", 65'(rdPtr), '0);
    check(outValid == 1'b0, "R1 valid", 65'(outValid), '0);
    step();
    rstN = 1'b1;
    step();

    // R2: one short dword is not enough
    rdyVal = 1'b1;
    putInst(1'b0, 31'h11);
    repeat (4) step();
    #4;
    check(outValid == 1'b0, "R2 threshold", 65'(outValid), '0);
    check(rdPtr == '0, "R2 ptr", 65'(rdPtr), '0);
    step();
    putInst(1'b0, 31'h12);
    step();
    #4;
    check(rdPtr == PTRW'(1), "R5 short step", 65'(rdPtr), 65'd1);
    step();

    // R5: long ending at the ring end wraps
    doFlush(PTRW'(14));
    putInst(1'b1, 31'h21);
    step();
    #4;
    check(rdPtr == PTRW'(16), "R5 wrap", 65'(rdPtr), 65'd16);
    check(expQ.size() == 0, "R5 taken", 65'(expQ.size()), '0);
    step();

    // R6/R3/R7: long instruction straddling the end
    rdyVal = 1'b0;
    doFlush(PTRW'(15));
    putInst(1'b1, 31'h31);
    step();
    #4;
    check(rdPtr == PTRW'(16), "R6 gather wrap", 65'(rdPtr), 65'd16);
    check(outValid && outLong && outInst == {32'hC0DE_0000 ^ 32'h31, 31'h31, 1'b1},
          "R6 stitched", {outLong, outInst}, {1'b1, 32'hC0DE_0031, 31'h31, 1'b1});
    repeat (3) step();
    #4;
    check(rdPtr == PTRW'(16) && outValid, "R3 hold", 65'(rdPtr), 65'd16);
    step();
    rdyVal = 1'b1;
    step();
    rdyVal = 1'b0;
    #4;
    check(rdPtr == PTRW'(17), "R7 long split step", 65'(rdPtr), 65'd17);
    check(expQ.size() == 0, "R7 taken", 65'(expQ.size()), '0);
    step();

    // R7: short instruction at the tail
    doFlush(PTRW'(15));
    putInst(1'b0, 31'h41);
    putInst(1'b0, 31'h42);
    step();
    #4;
    check(outValid && !outLong && outInst == {32'h0, 31'h41, 1'b0}, "R6 short wrap",
          {outLong, outInst}, {33'h0, 31'h41, 1'b0});
    step();
    rdyVal = 1'b1;
    step();
    rdyVal = 1'b0;
    #4;
    check(rdPtr == PTRW'(16), "R7 short split stays", 65'(rdPtr), 65'd16);
    check(outValid == 1'b0, "R2 after split", 65'(outValid), '0);
    step();

    // R8: flush while the wrapped half is held
    doFlush(PTRW'(15));
    putInst(1'b1, 31'h51);
    repeat (2) step();
    #4;
    check(outValid == 1'b1, "R6 held", 65'(outValid), 65'd1);
    step();
    doFlush(PTRW'(3));
    #4;
    check(rdPtr == PTRW'(3) && !outValid, "R8 reload", 65'(rdPtr), 65'd3);
    step();
    rdyVal = 1'b1;
    putInst(1'b1, 31'h52);
    drain();
    #4;
    check(expQ.size() == 0 && rdPtr == PTRW'(5), "R8 clean restart", 65'(rdPtr), 65'd5);
    step();

    // R9: long stream with backpressure
    rdyForce = 1'b0;
    for (int i = 0; i < 80; i++) putInst((i % 3) != 1, 31'(32'h100 + i));
    for (int i = 0; i < 2; i++) putInst(1'b0, 31'(32'h7F0 + i));
    drain();
    // last pad short lacks a partner dword, so one entry may remain
    check(expQ.size() <= 1, "R9 stream drained", 65'(expQ.size()), 65'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule